// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block produces the word address stream for a synchronous burst read from a 16-bit wide memory array. A start address is captured on a latch strobe, and from the next clock the block presents one word address per clock together with a data-valid flag. Bursts are fixed at 4, 8 or 16 words or run without end. A fixed burst either stays inside its aligned group of words (wrap) or keeps counting upward (no wrap).

A non-wrapping burst that starts in the last four words of a 16-word line cannot deliver the next line at once. The block inserts dead cycles at the first line crossing. During them the address holds at the last word of the line and the valid flag is low. A ready/wait output reports these cycles. Two configuration inputs set its polarity and whether it leads the dead cycle by one clock. Dropping the chip select freezes the burst, and a fresh strobe abandons it and starts again.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high and after it, `data_valid` is 0 and `rdy_wait` sits at its idle level, which is the inverse of `cfg_wait_pol`.
- R2: With `cfg_async` = 1 a latch strobe starts no burst, and `data_valid` is 0 from the next clock on.
- R3: A clock edge that sees `chip_sel` = 1, `lat_stb` = 1 and `cfg_async` = 0 loads `start_addr`. After that edge `word_addr` equals it and `data_valid` = 1, and each later clock with `chip_sel` high moves to the next word.
- R4: The `cfg_blen` codes are 0 = 4 words, 1 = 8 words, 2 = 16 words and 3 = unending. With `cfg_wrap` = 1 and a fixed length, the low address bits count modulo the length inside the aligned group, and the upper bits do not change (4 words from 1 give 1,2,3,0). With code 3 the address always increments.
- R5: With `cfg_wrap` = 0 the address increments by one per word. A fixed burst ends after its length in words, counting no dead cycles, and `data_valid` then drops to 0.
- R6: A non-wrapping burst whose start has address bits [3:2] = 3 inserts start[1:0] dead cycles at its first 16-word line crossing, and only there. During those cycles `data_valid` = 0 and `word_addr[3:0]` = 15. Any other start inserts none.
- R7: While `chip_sel` = 0 (and `cfg_async` = 0), `word_addr` and `data_valid` hold and the burst does not advance. It continues from the same point once `chip_sel` returns.
- R8: With `cfg_wait_pol` = 0 `rdy_wait` is low while waiting, and with `cfg_wait_pol` = 1 it is high while waiting.
- R9: With `cfg_wait_early` = 0 the wait indication covers exactly the dead cycles. With `cfg_wait_early` = 1 it covers the cycle before each dead cycle instead, so it starts one clock sooner and ends one clock sooner.
- R10: A strobe during a running burst, including one in a dead cycle, abandons the burst and restarts it from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_sel | input | 1 | Chip select, active high; low suspends the burst |
| lat_stb | input | 1 | Address latch strobe |
| start_addr | input | ADDR_W | Burst start word address |
| cfg_async | input | 1 | 1 = asynchronous read mode (no bursts), 0 = synchronous burst mode |
| cfg_wrap | input | 1 | 1 = wrap inside the burst group |
| cfg_blen | input | 2 | Burst length code |
| cfg_wait_pol | input | 1 | Level that `rdy_wait` takes while waiting |
| cfg_wait_early | input | 1 | 1 = wait indication one clock ahead |
| word_addr | output | ADDR_W | Current word address |
| data_valid | output | 1 | Current word is valid |
| rdy_wait | output | 1 | Ready/wait indication |

## Verification
A table of bursts covers wrap and no-wrap with every length code, and with start offsets 12 to 15 in a line and in a higher line. These cases separate a dead-cycle count that follows the start offset from a fixed count, and a single crossing penalty from a penalty at every crossing. Wrapped bursts of 8 and 16 words from offsets within the group show whether the group mask follows the length. Directed runs of the offset-14 burst under all four polarity and timing settings tell apart an indication that leads the dead cycles from one that covers them. Further runs drop the chip select mid-burst, strobe mid-burst and in a dead cycle, and strobe while in asynchronous mode.

// File: rtl/bas_pkg.sv
package bas_pkg;

    localparam int LINE_BITS = 4;
    localparam int WAIT_BITS = 2;
    localparam int CNT_BITS  = LINE_BITS + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic                 wrap_on;
        logic [CNT_BITS-1:0]  len;
        logic [LINE_BITS-1:0] mask;
    } burst_ctx_t;

    // length code to word count; 0 stands for an unending burst
    function automatic logic [CNT_BITS-1:0] burst_words(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_BITS'(4);
            2'd1:    return CNT_BITS'(8);
            2'd2:    return CNT_BITS'(16);
            default: return '0;
        endcase
    endfunction

    // dead cycles owed at the first line crossing for a given start offset
    function automatic logic [WAIT_BITS-1:0] line_waits(input logic [LINE_BITS-1:0] low);
        if (low[LINE_BITS-1:WAIT_BITS] == '1)
            return low[WAIT_BITS-1:0];
        return '0;
    endfunction

endpackage

// File: rtl/bas_start_dec.sv
module bas_start_dec
    import bas_pkg::*;
(
    input  logic [LINE_BITS-1:0] start_low,
    input  logic                 wrap_req,
    input  logic [1:0]           len_code,
    output burst_ctx_t           ctx,
    output logic [WAIT_BITS-1:0] waits
);
    logic [CNT_BITS-1:0] len;

    always_comb begin
        len         = burst_words(len_code);
        ctx.len     = len;
        ctx.wrap_on = wrap_req && (len != '0);
        ctx.mask    = LINE_BITS'(len - CNT_BITS'(1));
        waits       = ctx.wrap_on ? '0 : line_waits(start_low);
    end
endmodule

// File: rtl/bas_next_addr.sv
module bas_next_addr
    import bas_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic [ADDR_W-1:0]    cur,
    input  logic                 wrap_on,
    input  logic [LINE_BITS-1:0] mask,
    output logic [ADDR_W-1:0]    nxt
);
    logic [ADDR_W-1:0]    inc;
    logic [LINE_BITS-1:0] low_wrapped;

    always_comb begin
        inc         = cur + ADDR_W'(1);
        low_wrapped = (cur[LINE_BITS-1:0] & ~mask) | (inc[LINE_BITS-1:0] & mask);
        if (wrap_on)
            nxt = {cur[ADDR_W-1:LINE_BITS], low_wrapped};
        else
            nxt = inc;
    end
endmodule

// File: rtl/bas_wait_enc.sv
module bas_wait_enc
    import bas_pkg::*;
(
    input  seq_state_e           st,
    input  logic [WAIT_BITS-1:0] wrem,
    input  logic                 edge_pend,
    input  logic                 pol,
    input  logic                 early,
    output logic                 rdy_wait
);
    logic wait_now;
    logic wait_next;
    logic wait_on;

    always_comb begin
        wait_now  = (st == ST_WAIT);
        wait_next = edge_pend || (wait_now && (wrem > WAIT_BITS'(1)));
        wait_on   = early ? wait_next : wait_now;
        rdy_wait  = pol ? wait_on : ~wait_on;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel,
    input  logic              lat_stb,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              cfg_async,
    input  logic              cfg_wrap,
    input  logic [1:0]        cfg_blen,
    input  logic              cfg_wait_pol,
    input  logic              cfg_wait_early,
    output logic [ADDR_W-1:0] word_addr,
    output logic              data_valid,
    output logic              rdy_wait
);
    seq_state_e           st_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [CNT_BITS-1:0]  cnt_q;
    logic [WAIT_BITS-1:0] wrem_q;
    burst_ctx_t           ctx_q;

    burst_ctx_t           ctx_new;
    logic [WAIT_BITS-1:0] waits_new;
    logic [ADDR_W-1:0]    addr_nxt;
    logic                 done;
    logic                 edge_pend;

    bas_start_dec u_dec (
        .start_low (start_addr[LINE_BITS-1:0]),
        .wrap_req  (cfg_wrap),
        .len_code  (cfg_blen),
        .ctx       (ctx_new),
        .waits     (waits_new)
    );

    bas_next_addr #(.ADDR_W(ADDR_W)) u_step (
        .cur     (addr_q),
        .wrap_on (ctx_q.wrap_on),
        .mask    (ctx_q.mask),
        .nxt     (addr_nxt)
    );

    always_comb begin
        done      = (st_q == ST_DATA) && (ctx_q.len != '0) && (cnt_q == ctx_q.len);
        edge_pend = (st_q == ST_DATA) && !done && (addr_q[LINE_BITS-1:0] == '1)
                    && (wrem_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            cnt_q  <= '0;
            wrem_q <= '0;
            ctx_q  <= '0;
        end else if (cfg_async) begin
            st_q <= ST_IDLE;
        end else if (chip_sel) begin
            if (lat_stb) begin
                st_q   <= ST_DATA;
                addr_q <= start_addr;
                cnt_q  <= CNT_BITS'(1);
                wrem_q <= waits_new;
                ctx_q  <= ctx_new;
            end else begin
                case (st_q)
                    ST_DATA: begin
                        if (done) begin
                            st_q <= ST_IDLE;
                        end else if (edge_pend) begin
                            st_q <= ST_WAIT;
                        end else begin
                            addr_q <= addr_nxt;
                            cnt_q  <= cnt_q + CNT_BITS'(1);
                        end
                    end
                    ST_WAIT: begin
                        if (wrem_q == WAIT_BITS'(1)) begin
                            st_q   <= ST_DATA;
                            addr_q <= addr_nxt;
                            cnt_q  <= cnt_q + CNT_BITS'(1);
                        end
                        wrem_q <= wrem_q - WAIT_BITS'(1);
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    bas_wait_enc u_wait (
        .st        (st_q),
        .wrem      (wrem_q),
        .edge_pend (edge_pend),
        .pol       (cfg_wait_pol),
        .early     (cfg_wait_early),
        .rdy_wait  (rdy_wait)
    );

    assign word_addr  = addr_q;
    assign data_valid = (st_q == ST_DATA);

endmodule

// File: rtl/bas_checker.sv
module bas_checker
    import bas_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_sel,
    input logic              lat_stb,
    input logic              cfg_async,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] word_addr,
    input logic              data_valid,
    input logic              rdy_wait,
    input logic              cfg_wait_pol,
    input logic              cfg_wait_early,
    input seq_state_e        st_q
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !data_valid); // R1

    AST_ASYNC_NO_BURST: assert property (@(posedge clk) disable iff (rst)
        cfg_async |=> !data_valid); // R2

    AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (rst)
        (chip_sel && lat_stb && !cfg_async) |=>
        (data_valid && word_addr == $past(start_addr))); // R3

    AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!chip_sel && !cfg_async) |=> ($stable(word_addr) && $stable(data_valid))); // R7

    AST_WAIT_AT_LINE_END: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT) |-> (!data_valid && word_addr[LINE_BITS-1:0] == '1)); // R6

    AST_LATE_WAIT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wait_early && st_q == ST_WAIT) |-> (rdy_wait == cfg_wait_pol)); // R8

    AST_LATE_READY_ON_DATA: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wait_early && data_valid) |-> (rdy_wait != cfg_wait_pol)); // R9
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .chip_sel       (chip_sel),
    .lat_stb        (lat_stb),
    .cfg_async      (cfg_async),
    .start_addr     (start_addr),
    .word_addr      (word_addr),
    .data_valid     (data_valid),
    .rdy_wait       (rdy_wait),
    .cfg_wait_pol   (cfg_wait_pol),
    .cfg_wait_early (cfg_wait_early),
    .st_q           (st_q)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

    localparam int AW = 23;
    localparam int NV = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_sel = 1'b1;
    logic          lat_stb = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          cfg_async = 1'b0;
    logic          cfg_wrap = 1'b0;
    logic [1:0]    cfg_blen = 2'd0;
    logic          cfg_wait_pol = 1'b0;
    logic          cfg_wait_early = 1'b0;
    logic [AW-1:0] word_addr;
    logic          data_valid;
    logic          rdy_wait;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .chip_sel(chip_sel), .lat_stb(lat_stb),
        .start_addr(start_addr), .cfg_async(cfg_async), .cfg_wrap(cfg_wrap),
        .cfg_blen(cfg_blen), .cfg_wait_pol(cfg_wait_pol),
        .cfg_wait_early(cfg_wait_early), .word_addr(word_addr),
        .data_valid(data_valid), .rdy_wait(rdy_wait)
    );

    // each sequence entry: word address, FF = dead cycle, FE = burst over
    typedef struct packed {
        logic [7:0]  st;
        logic        wr;
        logic [1:0]  bl;
        logic [63:0] seq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        {8'h01, 1'b1, 2'd0, 64'h01020300FEFEFEFE},
        {8'h02, 1'b1, 2'd0, 64'h02030001FEFEFEFE},
        {8'h01, 1'b0, 2'd0, 64'h01020304FEFEFEFE},
        {8'h0C, 1'b0, 2'd0, 64'h0C0D0E0FFEFEFEFE},
        {8'h0D, 1'b0, 2'd0, 64'h0D0E0FFF10FEFEFE},
        {8'h0E, 1'b0, 2'd0, 64'h0E0FFFFF1011FEFE},
        {8'h0F, 1'b0, 2'd0, 64'h0FFFFFFF101112FE},
        {8'h05, 1'b1, 2'd1, 64'h0506070001020304},
        {8'h1D, 1'b0, 2'd0, 64'h1D1E1FFF20FEFEFE},
        {8'h0E, 1'b1, 2'd2, 64'h0E0F000102030405},
        {8'h0E, 1'b0, 2'd3, 64'h0E0FFFFF10111213},
        {8'h0A, 1'b0, 2'd1, 64'h0A0B0C0D0E0F1011},
        {8'h0D, 1'b0, 2'd1, 64'h0D0E0FFF10111213},
        {8'h09, 1'b1, 2'd1, 64'h090A0B0C0D0E0F08}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input int exp_addr);
        chk(data_valid === 1'b1, req, "valid", int'(data_valid), 1);
        chk(word_addr === AW'(exp_addr), req, "addr", int'(word_addr), exp_addr);
    endtask

    task automatic strobe(input int a);
        @(negedge clk);
        start_addr = AW'(a);
        lat_stb = 1'b1;
        @(negedge clk);
        lat_stb = 1'b0;
    endtask

    function automatic string tag_of(input vec_t v);
        bit has_wait = 0;
        for (int k = 0; k < 8; k++)
            if (v.seq[63-8*k -: 8] == 8'hFF) has_wait = 1;
        if (v.wr) return "R4";
        if (has_wait) return "R6";
        return "R5";
    endfunction

    // expected rdy_wait for the offset-14 four-word burst, entries e0..e4
    task automatic wait_mode(input bit pol, input bit early, input logic [4:0] exp);
        cfg_wait_pol = pol;
        cfg_wait_early = early;
        cfg_wrap = 1'b0;
        cfg_blen = 2'd0;
        strobe(14);
        for (int k = 0; k < 5; k++) begin
            chk(rdy_wait === exp[4-k], pol ? "R8" : "R9", "rdy_wait",
                int'(rdy_wait), int'(exp[4-k]));
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(data_valid === 1'b0, "R1", "valid in reset", int'(data_valid), 0);
        chk(rdy_wait === 1'b1, "R1", "rdy idle pol0", int'(rdy_wait), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(data_valid === 1'b0, "R1", "valid after reset", int'(data_valid), 0);
        cfg_wait_pol = 1'b1;
        #1;
        chk(rdy_wait === 1'b0, "R1", "rdy idle pol1", int'(rdy_wait), 0);
        cfg_wait_pol = 1'b0;

        // table of bursts (late, active-low wait)
        for (int v = 0; v < NV; v++) begin
            string tg;
            tg = tag_of(VECS[v]);
            cfg_wrap = VECS[v].wr;
            cfg_blen = VECS[v].bl;
            strobe(int'(VECS[v].st));
            for (int k = 0; k < 8; k++) begin
                logic [7:0] e;
                e = VECS[v].seq[63-8*k -: 8];
                if (e == 8'hFF) begin
                    chk(data_valid === 1'b0, tg, "dead valid", int'(data_valid), 0);
                    chk(rdy_wait === 1'b0, tg, "dead rdy", int'(rdy_wait), 0);
                end else if (e == 8'hFE) begin
                    chk(data_valid === 1'b0, tg, "end valid", int'(data_valid), 0);
                end else begin
                    chk_word(tg, int'(e));
                    chk(rdy_wait === 1'b1, tg, "ready", int'(rdy_wait), 1);
                end
                @(negedge clk);
            end
        end

        // R8 / R9: all four wait settings on the offset-14 burst
        wait_mode(1'b0, 1'b0, 5'b11001);
        wait_mode(1'b1, 1'b0, 5'b00110);
        wait_mode(1'b0, 1'b1, 5'b10011);
        wait_mode(1'b1, 1'b1, 5'b01100);
        cfg_wait_pol = 1'b0;
        cfg_wait_early = 1'b0;

        // R7: suspension mid-burst
        cfg_wrap = 1'b0;
        cfg_blen = 2'd0;
        strobe(13);
        chk_word("R7", 13);
        @(negedge clk);
        chk_word("R7", 14);
        chip_sel = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk_word("R7", 14);
        end
        chip_sel = 1'b1;
        @(negedge clk);
        chk_word("R7", 15);
        @(negedge clk);
        chk(data_valid === 1'b0, "R7", "dead after resume", int'(data_valid), 0);
        @(negedge clk);
        chk_word("R7", 16);

        // R10: restart mid-burst and from a dead cycle
        strobe(14);
        chk_word("R10", 14);
        @(negedge clk);
        chk_word("R10", 15);
        start_addr = AW'(40);
        lat_stb = 1'b1;
        @(negedge clk);
        lat_stb = 1'b0;
        chk_word("R10", 40);
        @(negedge clk);
        chk_word("R10", 41);
        strobe(15);
        chk_word("R10", 15);
        @(negedge clk);
        chk(data_valid === 1'b0, "R10", "in dead cycle", int'(data_valid), 0);
        start_addr = AW'(3);
        lat_stb = 1'b1;
        @(negedge clk);
        lat_stb = 1'b0;
        chk_word("R10", 3);
        chk(rdy_wait === 1'b1, "R10", "rdy after restart", int'(rdy_wait), 1);

        // R2: asynchronous mode ignores the strobe
        cfg_async = 1'b1;
        strobe(5);
        chk(data_valid === 1'b0, "R2", "valid async", int'(data_valid), 0);
        @(negedge clk);
        chk(data_valid === 1'b0, "R2", "valid async later", int'(data_valid), 0);
        cfg_async = 1'b0;
        @(negedge clk);
        chk(data_valid === 1'b0, "R2", "no burst left over", int'(data_valid), 0);

        // R3: high address bits carried through
        cfg_wrap = 1'b1;
        cfg_blen = 2'd0;
        strobe(23'h4_0007);
        chk_word("R3", 23'h4_0007);
        @(negedge clk);
        chk_word("R3", 23'h4_0004);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule